// File: doc/BRIEF.md
# Mode-Selectable Address/Data Pin Port

This block is a small memory-mapped port that controls four chip pins. Software configures it through three byte registers on a simple register bus: a direction register, a data register and a pull-up control register. Each pin can be an input, an output carrying a data bit, or an output carrying one of the low four bits of the internal address bus. Which of these roles a pin can take depends on the chip operating mode, a 3-bit input.

In the address-bus modes (1 to 4) the port is taken over completely. All four pins drive address bits, and software cannot change the direction setting. In the other modes every pin starts as an input after reset, and software decides which pins drive. In modes 5 and 6 a driven pin carries an address bit. In mode 7, and in the reserved mode 0, a driven pin carries its data register bit. The pads and the pull-up transistors sit outside the block. It only produces the output value, the output enable and the pull-up enable for each pin.

Top module: `pin_mux_port`

## Requirements
- R1: The direction register is at bus address 0xFFC8, the data register at 0xFFCA and the pull-up register at 0xFFDB. A write with `bus_we` high changes a register from the next rising clock edge onward. A read is combinational from the current register state. A read of any other address, or any cycle without `bus_re`, returns 0x00.
- R2: A read of the direction register always returns 0xFF, whatever its contents and whatever the mode.
- R3: In modes 1 to 4 the direction bits are all ones and writes to them are ignored. All four pins have `pin_oe` = 1 and `pin_out` equal to `int_addr`.
- R4: After a reset taken in mode 0, 5, 6 or 7, the direction bits are all zero, so every `pin_oe` is 0.
- R5: In modes 5 and 6, a pin whose direction bit is 1 has `pin_oe` = 1 and drives the matching `int_addr` bit.
- R6: In modes 7 and 0, a pin whose direction bit is 1 has `pin_oe` = 1 and drives the matching data register bit.
- R7: `pin_out` is 0 on every pin whose `pin_oe` is 0.
- R8: A data register read returns 1 in bits 7..4. In each bit i of 3..0 it returns the stored data bit if pin i is an output, and `pin_in[i]` if pin i is an input.
- R9: Reset clears the low four bits of the data and pull-up registers in every mode. Writes to bits 7..4 of any register are ignored. A pull-up register read returns 1 in bits 7..4 and the stored bits in 3..0.
- R10: `pin_pu[i]` is 1 only when pull-up bit i is 1, pin i is an input, and the mode is not 1 to 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 16 | Register bus address (low 16 bits) |
| bus_wdata | input | 8 | Register bus write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Register bus read data |
| op_mode | input | 3 | Chip operating mode, 0 to 7 |
| int_addr | input | 4 | Low four internal address bits to drive in address-routing modes |
| pin_in | input | 4 | Sampled pin levels |
| pin_out | output | 4 | Value to drive on each pin |
| pin_oe | output | 4 | Output enable per pin |
| pin_pu | output | 4 | Pull-up enable per pin |

## Verification
The assertions guard properties that must hold every cycle. They check that the direction bits stay frozen while the port is locked to the address bus, that locked pins mirror `int_addr`, that no pin ever has both pull-up and output enabled, that undriven pins output 0, that data writes land one edge later, and that direction reads return all ones. The bench's scenarios cover the rest, because it depends on history: reset values taken in different modes, the per-bit mix of stored data and pin levels in data reads, and mode changes without a reset that keep a direction pattern written earlier. The selection between address and data sources across modes 0, 5, 6 and 7 is also checked only by the bench.

// File: rtl/pmp_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the mode-selectable pin port.
// Assumes the operating mode is a 3-bit code 0..7.
package pmp_pkg;

    // How the port behaves for the current operating mode.
    typedef enum logic [1:0] {
        PM_LOCKED   = 2'd0,  // every pin forced to drive an address bit
        PM_ADDR_SEL = 2'd1,  // set direction bits select address output
        PM_DATA_SEL = 2'd2   // set direction bits select data output
    } mode_class_e;

    // Map a raw operating mode to its behaviour class.
    function automatic mode_class_e classify_mode(input logic [2:0] m);
        if (m >= 3'd1 && m <= 3'd4)       return PM_LOCKED;
        else if (m == 3'd5 || m == 3'd6)  return PM_ADDR_SEL;
        else                              return PM_DATA_SEL;
    endfunction

endpackage

// File: rtl/pmp_mode_decode.sv
`timescale 1ns/1ps
// Module: pmp_mode_decode
// Turns the operating mode code into the behaviour class and the flags
// that the register and pin logic consume. Purely combinational.
// Assumes op_mode is stable around clock edges.
module pmp_mode_decode
    import pmp_pkg::*;
(
    input  logic [2:0]   op_mode,
    output mode_class_e  mode_class,
    output logic         mode_locked,
    output logic         addr_route
);

    // Classify the mode and derive the flags.
    always_comb begin
        mode_class  = classify_mode(op_mode);
        mode_locked = (mode_class == PM_LOCKED);
        addr_route  = (mode_class != PM_DATA_SEL);
    end

endmodule

// File: rtl/pmp_regs.sv
`timescale 1ns/1ps
// Module: pmp_regs
// Holds the direction, data and pull-up registers and serves bus reads.
// Assumes a synchronous active-low reset and a mode that is valid during
// reset. Only the low NPINS bits of each register are stored. The upper
// bits are constant ones on read and are ignored on write.
module pmp_regs #(
    parameter int               NPINS    = 4,
    parameter int               DW       = 8,
    parameter int               AW       = 16,
    parameter logic [AW-1:0]    DIR_ADDR = 16'hFFC8,
    parameter logic [AW-1:0]    DAT_ADDR = 16'hFFCA,
    parameter logic [AW-1:0]    PUP_ADDR = 16'hFFDB
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    input  logic             bus_we,
    input  logic             bus_re,
    input  logic             mode_locked,
    input  logic [NPINS-1:0] pin_in,
    output logic [DW-1:0]    bus_rdata,
    output logic [NPINS-1:0] dir_eff,
    output logic [NPINS-1:0] dat_q,
    output logic [NPINS-1:0] pup_q
);

    localparam int FILL = DW - NPINS;

    logic [NPINS-1:0] dir_q;
    logic             wr_dir, wr_dat, wr_pup;
    logic             unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[DW-1:NPINS];

    // Decode which register a write strobe targets.
    always_comb begin
        wr_dir = bus_we && (bus_addr == DIR_ADDR) && !mode_locked;
        wr_dat = bus_we && (bus_addr == DAT_ADDR);
        wr_pup = bus_we && (bus_addr == PUP_ADDR);
    end

    // Direction register: its reset value depends on the mode, and it is frozen while locked.
    always_ff @(posedge clk) begin
        if (!rst_n)      dir_q <= mode_locked ? '1 : '0;
        else if (wr_dir) dir_q <= bus_wdata[NPINS-1:0];
    end

    // Data register: clears on reset, stores the low bits on write.
    always_ff @(posedge clk) begin
        if (!rst_n)      dat_q <= '0;
        else if (wr_dat) dat_q <= bus_wdata[NPINS-1:0];
    end

    // Pull-up register: clears on reset, stores the low bits on write.
    always_ff @(posedge clk) begin
        if (!rst_n)      pup_q <= '0;
        else if (wr_pup) pup_q <= bus_wdata[NPINS-1:0];
    end

    // Effective direction: all outputs while the mode locks the port.
    assign dir_eff = mode_locked ? '1 : dir_q;

    // Read multiplexer: combinational from current state, zero when idle.
    always_comb begin
        bus_rdata = '0;
        if (bus_re) begin
            if (bus_addr == DIR_ADDR)
                bus_rdata = '1;
            else if (bus_addr == DAT_ADDR)
                bus_rdata = {{FILL{1'b1}}, (dir_eff & dat_q) | (~dir_eff & pin_in)};
            else if (bus_addr == PUP_ADDR)
                bus_rdata = {{FILL{1'b1}}, pup_q};
        end
    end

    // R3
    dir_lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_locked |=> $stable(dir_q));

    // R1
    dat_write_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == DAT_ADDR) |=> (dat_q == $past(bus_wdata[NPINS-1:0])));

endmodule

// File: rtl/pmp_pinmux.sv
`timescale 1ns/1ps
// Module: pmp_pinmux
// Per-pin output selection: the address bit or the data bit as the
// source, direction as the enable, and pull-up gating. Combinational.
// Assumes dir_eff already has the mode lock applied.
module pmp_pinmux #(
    parameter int NPINS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_locked,
    input  logic             addr_route,
    input  logic [NPINS-1:0] dir_eff,
    input  logic [NPINS-1:0] dat_q,
    input  logic [NPINS-1:0] pup_q,
    input  logic [NPINS-1:0] int_addr,
    output logic [NPINS-1:0] pin_out,
    output logic [NPINS-1:0] pin_oe,
    output logic [NPINS-1:0] pin_pu
);

    // One identical slice per pin.
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        assign pin_oe[i]  = dir_eff[i];
        assign pin_out[i] = dir_eff[i] & (addr_route ? int_addr[i] : dat_q[i]);
        assign pin_pu[i]  = pup_q[i] & ~dir_eff[i] & ~mode_locked;
    end

    // R3
    locked_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_locked |-> (pin_oe == '1 && pin_out == int_addr));

    // R10
    pu_vs_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_pu & pin_oe) == '0);

    // R7
    idle_pin_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out & ~pin_oe) == '0);

endmodule

// File: rtl/pin_mux_port.sv
`timescale 1ns/1ps
// Module: pin_mux_port
// Top of the mode-selectable address/data pin port. Wires the mode
// decoder, the register file and the per-pin multiplexer together.
// Assumes a synchronous active-low reset taken with a valid op_mode.
module pin_mux_port #(
    parameter int               NPINS    = 4,
    parameter int               DW       = 8,
    parameter int               AW       = 16,
    parameter logic [AW-1:0]    DIR_ADDR = 16'hFFC8,
    parameter logic [AW-1:0]    DAT_ADDR = 16'hFFCA,
    parameter logic [AW-1:0]    PUP_ADDR = 16'hFFDB
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    input  logic             bus_we,
    input  logic             bus_re,
    output logic [DW-1:0]    bus_rdata,
    input  logic [2:0]       op_mode,
    input  logic [NPINS-1:0] int_addr,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] pin_out,
    output logic [NPINS-1:0] pin_oe,
    output logic [NPINS-1:0] pin_pu
);

    import pmp_pkg::*;

    mode_class_e      mode_class;
    logic             mode_locked, addr_route;
    logic [NPINS-1:0] dir_eff, dat_q, pup_q;
    logic             unused_class;

    assign unused_class = ^mode_class;

    pmp_mode_decode u_dec (
        .op_mode     (op_mode),
        .mode_class  (mode_class),
        .mode_locked (mode_locked),
        .addr_route  (addr_route)
    );

    pmp_regs #(
        .NPINS(NPINS), .DW(DW), .AW(AW),
        .DIR_ADDR(DIR_ADDR), .DAT_ADDR(DAT_ADDR), .PUP_ADDR(PUP_ADDR)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_we      (bus_we),
        .bus_re      (bus_re),
        .mode_locked (mode_locked),
        .pin_in      (pin_in),
        .bus_rdata   (bus_rdata),
        .dir_eff     (dir_eff),
        .dat_q       (dat_q),
        .pup_q       (pup_q)
    );

    pmp_pinmux #(.NPINS(NPINS)) u_mux (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_locked (mode_locked),
        .addr_route  (addr_route),
        .dir_eff     (dir_eff),
        .dat_q       (dat_q),
        .pup_q       (pup_q),
        .int_addr    (int_addr),
        .pin_out     (pin_out),
        .pin_oe      (pin_oe),
        .pin_pu      (pin_pu)
    );

    // R2
    dir_read_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && bus_addr == DIR_ADDR) |-> (bus_rdata == '1));

endmodule

// File: tb/pin_mux_port_bench.sv
`timescale 1ns/1ps
// Bench for pin_mux_port: directed corner cases, then seeded random
// traffic, each compared with a reference model written from the requirements.
module pin_mux_port_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_we = 1'b0, bus_re = 1'b0;
    logic [7:0]  bus_rdata;
    logic [2:0]  op_mode = 3'd5;
    logic [3:0]  int_addr = '0, pin_in = '0;
    logic [3:0]  pin_out, pin_oe, pin_pu;

    int checks = 0, errors = 0;
    bit done = 0;

    logic [3:0] m_dir, m_dat, m_pup;

    always #2.5 clk = ~clk;

    pin_mux_port u_pin_mux_port (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .op_mode(op_mode), .int_addr(int_addr), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu)
    );

    function automatic bit is_locked(input logic [2:0] m);
        return (m >= 3'd1 && m <= 3'd4);
    endfunction

    function automatic bit is_addr(input logic [2:0] m);
        return is_locked(m) || m == 3'd5 || m == 3'd6;
    endfunction

    function automatic logic [3:0] exp_oe();
        return is_locked(op_mode) ? 4'hF : m_dir;
    endfunction

    function automatic logic [3:0] exp_out();
        return exp_oe() & (is_addr(op_mode) ? int_addr : m_dat);
    endfunction

    function automatic logic [3:0] exp_pu();
        return is_locked(op_mode) ? 4'h0 : (m_pup & ~exp_oe());
    endfunction

    function automatic logic [7:0] exp_rd();
        if (!bus_re) return 8'h00;
        case (bus_addr)
            16'hFFC8: return 8'hFF;
            16'hFFCA: return {4'hF, (exp_oe() & m_dat) | (~exp_oe() & pin_in)};
            16'hFFDB: return {4'hF, m_pup};
            default:  return 8'h00;
        endcase
    endfunction

    function automatic string rd_tag();
        case (bus_addr)
            16'hFFC8: return "R2";
            16'hFFCA: return "R8";
            16'hFFDB: return "R9";
            default:  return "R1";
        endcase
    endfunction

    function automatic string mode_tag();
        if (is_locked(op_mode)) return "R3";
        if (is_addr(op_mode))   return "R5";
        return "R6";
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s mode=%0d actual=%h expected=%h", req, op_mode, act, exp);
        end
    endtask

    // Compare every output with the model for the current cycle.
    task automatic check_all();
        check(mode_tag(), {4'h0, pin_oe}, {4'h0, exp_oe()});
        check(mode_tag(), {4'h0, pin_out}, {4'h0, exp_out()});
        check("R7", {4'h0, pin_out & ~pin_oe}, 8'h00);
        check("R10", {4'h0, pin_pu}, {4'h0, exp_pu()});
        check(rd_tag(), bus_rdata, exp_rd());
    endtask

    // One bus cycle: drive at the falling edge, check, then commit on the rising edge.
    task automatic step(input logic [15:0] a, input logic [7:0] wd, input bit we,
                        input bit re, input logic [3:0] pins, input logic [3:0] ia);
        @(negedge clk);
        bus_addr = a; bus_wdata = wd; bus_we = we; bus_re = re;
        pin_in = pins; int_addr = ia;
        #1;
        check_all();
        @(posedge clk);
        if (we) begin
            if (a == 16'hFFC8 && !is_locked(op_mode)) m_dir = wd[3:0];
            if (a == 16'hFFCA) m_dat = wd[3:0];
            if (a == 16'hFFDB) m_pup = wd[3:0];
        end
    endtask

    // Synchronous reset taken in the given mode, followed by a check of the reset state.
    task automatic do_reset(input logic [2:0] m);
        @(negedge clk);
        rst_n = 1'b0; op_mode = m; bus_we = 1'b0; bus_re = 1'b0;
        @(posedge clk);
        m_dir = is_locked(m) ? 4'hF : 4'h0;
        m_dat = 4'h0; m_pup = 4'h0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        if (!is_locked(m)) check("R4", {4'h0, pin_oe}, 8'h00);
        else               check("R3", {4'h0, pin_oe}, 8'h0F);
    endtask

    initial begin
        void'($urandom(32'd4711));
        // Reset state in a routing mode: all inputs, registers cleared (R4, R9)
        do_reset(3'd5);
        step(16'hFFDB, 8'h00, 0, 1, 4'h9, 4'h3);   // R9 pull-up reads F0
        step(16'hFFCA, 8'h00, 0, 1, 4'h6, 4'h3);   // R8 inputs read pin levels
        step(16'hFFC8, 8'h00, 0, 1, 4'h6, 4'h3);   // R2 direction reads FF
        // R1 write lands next edge; R9 upper bits ignored
        step(16'hFFCA, 8'h5A, 1, 1, 4'h0, 4'h0);
        step(16'hFFCA, 8'h00, 0, 1, 4'h0, 4'h0);
        step(16'hFFDB, 8'hF3, 1, 0, 4'h0, 4'h0);
        step(16'hFFDB, 8'h00, 0, 1, 4'h0, 4'h0);   // R10 pull-ups on inputs
        // R5 half the pins drive address bits
        step(16'hFFC8, 8'h05, 1, 0, 4'hF, 4'hA);
        step(16'hFFCA, 8'h00, 0, 1, 4'hF, 4'hF);
        step(16'h1234, 8'h00, 0, 1, 4'hF, 4'h5);   // R1 unmapped read returns 0
        // R6 mode 7 drives data bits with the direction kept
        op_mode = 3'd7;
        step(16'hFFC8, 8'h00, 0, 1, 4'h0, 4'hF);
        // R3 locked mode: direction writes ignored, all pins address
        do_reset(3'd2);
        step(16'hFFC8, 8'h00, 1, 1, 4'h0, 4'h9);
        step(16'hFFCA, 8'h00, 0, 1, 4'h3, 4'h6);
        step(16'hFFDB, 8'hFF, 1, 0, 4'h0, 4'hC);
        step(16'hFFDB, 8'h00, 0, 1, 4'h0, 4'h1);   // R10 no pull-ups while locked
        // Reserved mode 0 behaves as mode 7 (R6)
        do_reset(3'd0);
        step(16'hFFCA, 8'h0C, 1, 0, 4'h0, 4'h0);
        step(16'hFFC8, 8'h0E, 1, 0, 4'h0, 4'h0);
        step(16'hFFCA, 8'h00, 0, 1, 4'h5, 4'h3);
        // Seeded random traffic
        for (int n = 0; n < 3000; n++) begin
            logic [15:0] a;
            int sel;
            if ($urandom_range(0, 99) == 0) do_reset(3'($urandom_range(0, 7)));
            if ($urandom_range(0, 149) == 0) op_mode = 3'($urandom_range(0, 7));
            sel = $urandom_range(0, 3);
            a = (sel == 0) ? 16'hFFC8 : (sel == 1) ? 16'hFFCA :
                (sel == 2) ? 16'hFFDB : 16'($urandom);
            step(a, 8'($urandom), bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
                 4'($urandom), 4'($urandom));
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule